// File: doc/BRIEF.md
# Block Transfer Sequencer

This block steps through one multi-register memory transfer. A start pulse captures a 16-bit register mask, a base address and five control bits: pre/post offset, up/down direction, privileged-state pass-through, writeback enable and load/store. Once a transfer begins, the sequencer issues one memory transfer per cycle. Each transfer carries a register index, a word address and a direction. After the last transfer it raises a one-cycle completion strobe. If writeback is enabled, the updated base value is presented in the same cycle.

The same engine serves all four stack disciplines: full or empty, ascending or descending. Register numbers always rise with addresses, so the lowest selected register sits at the lowest word. The pre/post and up/down bits only choose where that window starts. A surrounding datapath supplies the register file and the memory port, and it drives start only while the sequencer is idle. Start pulses that arrive while busy are dropped.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, busy, done, xfer_valid and wb_valid are all low.
- R2: A start seen while idle launches an operation. xfer_valid is high in exactly N consecutive cycles, starting in the cycle after start, where N is the number of set bits in the mask.
- R3: Mask bit n selects register n. The transfers visit the selected registers in strictly ascending index order, and xfer_reg gives the index of each one.
- R4: The first address is base+4 for up/pre (up=1, pre_idx=1), base for up/post, base-4N for down/pre, and base-4N+4 for down/post. Each later transfer is the previous address plus 4.
- R5: During every transfer, xfer_load equals the load bit (1 = load, 0 = store) and xfer_psr equals the privileged-state bit captured at start.
- R6: done is high for exactly one cycle, the cycle after the last transfer. busy is high from the cycle after start through the done cycle, and low afterwards.
- R7: wb_valid is high together with done only when writeback was requested and the mask was non-empty. wb_value is then base+4N when up=1 and base-4N when up=0.
- R8: An all-zero mask gives done in the cycle after start, with no transfer and no writeback.
- R9: A start pulse and changed operands while busy is high, including the done cycle, have no effect. The transfer stream, done and writeback all follow the operation captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only while idle |
| reg_list | input | 16 | Register selection mask, bit n = register n |
| base_addr | input | 32 | Base register value |
| pre_idx | input | 1 | 1 = step before each transfer, 0 = after |
| up | input | 1 | 1 = ascending, 0 = descending |
| psr_force | input | 1 | Privileged-state request, passed through |
| wb_en | input | 1 | Write final address back to base |
| load_dir | input | 1 | 1 = load, 0 = store |
| busy | output | 1 | Operation in progress |
| xfer_valid | output | 1 | A transfer is issued this cycle |
| xfer_reg | output | 4 | Register index of the current transfer |
| xfer_addr | output | 32 | Word address of the current transfer |
| xfer_load | output | 1 | Direction of the current transfer |
| xfer_psr | output | 1 | Captured privileged-state bit |
| done | output | 1 | One-cycle completion strobe |
| wb_valid | output | 1 | Base writeback is due this cycle |
| wb_value | output | 32 | New base value |

## Verification
Two events share one cycle: the completion strobe and the base writeback. A stray start pulse can also arrive in that same cycle, when busy is about to fall. The bench runs operations with writeback on and off, including an all-zero mask. It holds start high with unrelated operands through every busy cycle up to and including the done cycle. It then requires the writeback value to match the first operation, done to last exactly one cycle, and no new transfer to begin once busy falls.

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int LIST_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LIST_W-1:0] reg_list,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              pre_idx,
  input  logic              up,
  input  logic              psr_force,
  input  logic              wb_en,
  input  logic              load_dir,
  output logic              busy,
  output logic              xfer_valid,
  output logic [$clog2(LIST_W)-1:0] xfer_reg,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_load,
  output logic              xfer_psr,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value
);
  localparam int IDX_W = $clog2(LIST_W);
  localparam int CNT_W = $clog2(LIST_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} state_t;

  state_t            state;
  logic [LIST_W-1:0] rem;
  logic [ADDR_W-1:0] addr_q, wbv_q;
  logic              load_q, psr_q, wb_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span, first_addr;
  logic [IDX_W-1:0]  low_idx;
  logic [LIST_W-1:0] rem_next;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LIST_W; i++) cnt = cnt + CNT_W'(reg_list[i]);
  end

  always_comb begin
    low_idx = '0;
    for (int i = LIST_W - 1; i >= 0; i--) if (rem[i]) low_idx = IDX_W'(i);
  end

  assign span       = ADDR_W'(cnt) << 2;
  assign first_addr = up ? (pre_idx ? base_addr + ADDR_W'(4) : base_addr)
                         : (pre_idx ? base_addr - span : base_addr - span + ADDR_W'(4));
  assign rem_next   = rem & (rem - LIST_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rem    <= '0;
      addr_q <= '0;
      wbv_q  <= '0;
      load_q <= 1'b0;
      psr_q  <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          rem    <= reg_list;
          addr_q <= first_addr;
          wbv_q  <= up ? base_addr + span : base_addr - span;
          load_q <= load_dir;
          psr_q  <= psr_force;
          wb_q   <= wb_en && (reg_list != '0);
          state  <= (reg_list == '0) ? S_FIN : S_XFER;
        end
        S_XFER: begin
          rem    <= rem_next;
          addr_q <= addr_q + ADDR_W'(4);
          if (rem_next == '0) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign xfer_valid = (state == S_XFER);
  assign xfer_reg   = low_idx;
  assign xfer_addr  = addr_q;
  assign xfer_load  = load_q;
  assign xfer_psr   = psr_q;
  assign done       = (state == S_FIN);
  assign wb_valid   = done && wb_q;
  assign wb_value   = wbv_q;

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && $past(xfer_valid) |-> xfer_addr == $past(xfer_addr) + ADDR_W'(4));

  p_reg_rising_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && $past(xfer_valid) |-> xfer_reg > $past(xfer_reg));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  p_hold_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(xfer_load) && $stable(xfer_psr));

  p_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> rem[xfer_reg]);
endmodule

// File: tb/test_blkxfer_seq.sv
`timescale 1ns/1ps
module test_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic        pre_idx = 1'b0, up = 1'b0, psr_force = 1'b0, wb_en = 1'b0, load_dir = 1'b0;
  logic        busy, xfer_valid, xfer_load, xfer_psr, done, wb_valid;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr, wb_value;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  blkxfer_seq i_blkxfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list), .base_addr(base_addr),
    .pre_idx(pre_idx), .up(up), .psr_force(psr_force), .wb_en(wb_en), .load_dir(load_dir),
    .busy(busy), .xfer_valid(xfer_valid), .xfer_reg(xfer_reg), .xfer_addr(xfer_addr),
    .xfer_load(xfer_load), .xfer_psr(xfer_psr), .done(done), .wb_valid(wb_valid),
    .wb_value(wb_value));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int nth_reg(input logic [15:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin
      if (seen == k) return i;
      seen++;
    end
    return -1;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input int n, input bit p, input bit u);
    if (u) return p ? b + 32'd4 : b;
    return p ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
  endfunction

  task automatic run_op(input logic [15:0] m, input logic [31:0] b, input bit p, input bit u,
                        input bit s, input bit w, input bit l, input bit spam);
    int n = popc(m);
    logic [31:0] a0 = exp_first(b, n, p, u);
    logic [31:0] wbx = u ? b + 32'(4 * n) : b - 32'(4 * n);
    @(negedge clk);
    reg_list = m; base_addr = b; pre_idx = p; up = u; psr_force = s; wb_en = w; load_dir = l;
    start = 1'b1;
    @(negedge clk);
    start = spam;
    for (int k = 0; k < n; k++) begin
      if (spam) begin
        reg_list = 16'($urandom); base_addr = $urandom;
        {pre_idx, up, psr_force, wb_en, load_dir} = 5'($urandom);
      end
      chk(xfer_valid === 1'b1 && busy === 1'b1 && done === 1'b0, "R2", {30'd0, busy, xfer_valid}, 32'd3);
      chk(xfer_reg === 4'(nth_reg(m, k)), "R3", {28'd0, xfer_reg}, 32'(nth_reg(m, k)));
      chk(xfer_addr === a0 + 32'(4 * k), "R4", xfer_addr, a0 + 32'(4 * k));
      chk(xfer_load === l && xfer_psr === s, "R5", {30'd0, xfer_load, xfer_psr}, {30'd0, l, s});
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b1 && xfer_valid === 1'b0,
        n == 0 ? "R8" : "R6", {29'd0, done, busy, xfer_valid}, 32'd6);
    chk(wb_valid === (w && n != 0), spam ? "R9" : (n == 0 ? "R8" : "R7"), {31'd0, wb_valid}, {31'd0, w && n != 0});
    if (w && n != 0) chk(wb_value === wbx, spam ? "R9" : "R7", wb_value, wbx);
    start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && xfer_valid === 1'b0, spam ? "R9" : "R6",
        {29'd0, busy, done, xfer_valid}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    #1;
    chk(busy === 1'b0 && done === 1'b0 && xfer_valid === 1'b0 && wb_valid === 1'b0, "R1",
        {28'd0, busy, done, xfer_valid, wb_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(busy === 1'b0 && done === 1'b0 && xfer_valid === 1'b0 && wb_valid === 1'b0, "R1",
        {28'd0, busy, done, xfer_valid, wb_valid}, 32'd0);
    // full-descending push of R4..R6, then matching pop including R15
    run_op(16'h0070, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(16'h8070, 32'h0000_0FF4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h0000, 32'h0000_2000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(16'h0000, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_op(16'hFFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    run_op(16'h8000, 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(16'h0001, 32'h0000_0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int t = 0; t < 300; t++) begin
      logic [15:0] m;
      case (t % 4)
        0: m = 16'($urandom);
        1: m = 16'($urandom) & 16'($urandom) & 16'($urandom);
        2: m = 16'h1 << ($urandom % 16);
        default: m = ~(16'h1 << ($urandom % 16));
      endcase
      run_op(m, $urandom & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule